// File: doc/BRIEF.md
# Circular Register Pointer with Post-Increment

This block produces the register address for indirect accesses into a 512-entry register space. A processor core sends a set command with a packed descriptor that gives a circular window: its first address and its last address. From then on, each access strobe uses the current pointer as the address and then moves the pointer on by one. When the pointer is at the window's last address, it returns to the window's first address. Software never has to wrap the pointer itself.

A typical use is a capture loop. The loop writes samples through the pointer into a buffer of N registers. After N accesses the next sample lands on the buffer's first register again. The register file and the instruction decoder sit outside this block. They see only the address output and drive only the set and access inputs.

Top module: `circ_ptr`

## Requirements
- R1: While `rst_ni` is low, and after its release until the first set command, the window runs from base 0 to last address 511 and `addr_o` reads 0.
- R2: The descriptor `desc_i` carries the window base in bits [8:0] and the window's last address in bits [17:9]. A window of N entries starting at B is written as ((B+N-1) << 9) + B.
- R3: A set command without an access loads the pointer with the base and latches both bounds. The cycle after it, `addr_o` equals the base.
- R4: An access whose address is neither the last address nor 511 presents that address on `addr_o` in its own cycle. `addr_o` shows that address plus one in the next cycle.
- R5: In a cycle with neither a set command nor an access, the pointer and the bounds keep their values. `addr_o` is unchanged in the next cycle.
- R6: An access whose address equals the window's last address makes `addr_o` equal the base in the next cycle.
- R7: If the last address is below the base, the pointer counts up to 511 and then returns to the base. An access at address 511 always returns the pointer to the base, and `addr_o` never leaves 0..511.
- R8: When a set command and an access arrive in the same cycle, the set command wins. The access uses the new base as its address in that cycle, and the pointer then moves on from that base with the new bounds.
- R9: For a window of N entries, N consecutive accesses after a set command visit each address of the window exactly once, in order. Access N+1 uses the base again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| set_i | input | 1 | Load pointer and window from `desc_i` |
| desc_i | input | 18 | Packed window descriptor: last address [17:9], base [8:0] |
| access_i | input | 1 | Access strobe: use the pointer, then advance it |
| addr_o | output | 9 | Register address for the current access |

## Verification
`addr_o` is combinational from the pointer register and the set inputs, so the address an access uses is valid in the same cycle as the strobe. The effect of the pointer update (increment, wrap, load or hold) appears on `addr_o` exactly one clock edge later. The bench drives inputs on the falling edge and compares `addr_o` a short delay later, before the next rising edge. A behavioural model updates its state at each rising edge, so every cycle checks both the same-cycle address and the one-edge-late update of the previous cycle.

// File: rtl/circ_ptr_pkg.sv
package circ_ptr_pkg;
  parameter int unsigned ADDR_W = 9;
  parameter int unsigned DESC_W = 2 * ADDR_W;

  typedef logic [ADDR_W-1:0] addr_t;

  typedef struct packed {
    addr_t last;
    addr_t base;
  } window_t;

  localparam addr_t ADDR_MAX = '1;
endpackage

// File: rtl/circ_ptr_desc_dec.sv
module circ_ptr_desc_dec
  import circ_ptr_pkg::*;
(
  input  logic [DESC_W-1:0] desc_i,
  output window_t           win_o
);
  // upper half is the last address, lower half the base
  assign win_o.base = desc_i[ADDR_W-1:0];
  assign win_o.last = desc_i[DESC_W-1:ADDR_W];
endmodule

// File: rtl/circ_ptr_step.sv
module circ_ptr_step
  import circ_ptr_pkg::*;
(
  input  addr_t   cur_i,
  input  window_t win_i,
  input  logic    adv_i,
  output addr_t   nxt_o
);
  logic at_end;

  // top of space also wraps, covering windows whose last < base
  assign at_end = (cur_i == win_i.last) || (cur_i == ADDR_MAX);

  always_comb begin
    if (!adv_i)      nxt_o = cur_i;
    else if (at_end) nxt_o = win_i.base;
    else             nxt_o = cur_i + addr_t'(1);
  end
endmodule

// File: rtl/circ_ptr.sv
module circ_ptr
  import circ_ptr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_i,
  input  logic [DESC_W-1:0] desc_i,
  input  logic              access_i,
  output logic [ADDR_W-1:0] addr_o
);
  window_t win_q, win_new, win_use;
  addr_t   ptr_q, cur, ptr_d;

  circ_ptr_desc_dec u_dec (
    .desc_i (desc_i),
    .win_o  (win_new)
  );

  // set has priority: a same-cycle access sees the new window
  assign win_use = set_i ? win_new : win_q;
  assign cur     = set_i ? win_new.base : ptr_q;

  circ_ptr_step u_step (
    .cur_i (cur),
    .win_i (win_use),
    .adv_i (access_i),
    .nxt_o (ptr_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q      <= '0;
      win_q.base <= '0;
      win_q.last <= ADDR_MAX;
    end else begin
      ptr_q <= ptr_d;
      if (set_i) win_q <= win_new;
    end
  end

  assign addr_o = cur;

  p_set_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && !access_i) |=> (addr_o == $past(desc_i[ADDR_W-1:0])) || set_i);

  p_inc_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_i && access_i && ptr_q != win_q.last && ptr_q != ADDR_MAX)
      |=> ptr_q == $past(ptr_q) + addr_t'(1));

  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_i && !access_i) |=> $stable(ptr_q) && $stable(win_q));

  p_wrap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_i && access_i && ptr_q == win_q.last) |=> ptr_q == $past(win_q.base));

  p_top_wrap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_i && access_i && ptr_q == ADDR_MAX) |=> ptr_q == $past(win_q.base));

  p_set_first_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && access_i && desc_i[ADDR_W-1:0] != desc_i[DESC_W-1:ADDR_W]
     && desc_i[ADDR_W-1:0] != ADDR_MAX)
      |=> ptr_q == $past(desc_i[ADDR_W-1:0]) + addr_t'(1));
endmodule

// File: tb/circ_ptr_bench.sv
module circ_ptr_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        set_i = 1'b0;
  logic [17:0] desc_i = '0;
  logic        access_i = 1'b0;
  logic [8:0]  addr_o;

  int checks = 0;
  int errors = 0;
  int m_ptr = 0, m_base = 0, m_last = 511;
  bit done = 0;

  circ_ptr u_circ_ptr (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(set_i),
    .desc_i(desc_i), .access_i(access_i), .addr_o(addr_o)
  );

  always #10 clk_i = ~clk_i;

  function automatic logic [17:0] mk(int b, int l);
    return {l[8:0], b[8:0]};
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s addr actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one cycle: drive, compare same-cycle address, advance model at the edge
  task automatic step(bit s, int b, int l, bit a, string req);
    int use_addr, nb, nl, np;
    @(negedge clk_i);
    set_i = s; desc_i = mk(b, l); access_i = a;
    #2;
    nb = s ? b : m_base;
    nl = s ? l : m_last;
    use_addr = s ? b : m_ptr;
    chk(req, int'(addr_o), use_addr);
    np = use_addr;
    if (a) np = (use_addr == nl || use_addr == 511) ? nb : use_addr + 1;
    @(posedge clk_i);
    m_ptr = np; m_base = nb; m_last = nl;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    #35;
    chk("R1 in reset", int'(addr_o), 0);
    rst_ni = 1'b1;
    step(0, 0, 0, 0, "R1 after reset");
    step(0, 0, 0, 0, "R5 idle");
    for (int i = 0; i < 5; i++) step(0, 0, 0, 1, "R1 R4 full window");
    step(0, 0, 0, 0, "R5 hold");
    step(1, 10, 13, 0, "R2 R3 set");
    for (int i = 0; i < 9; i++) step(0, 0, 0, 1, "R4 R6 window 10..13");
    step(1, 40, 42, 1, "R8 set with access");
    step(0, 0, 0, 1, "R8 continue");
    step(0, 0, 0, 1, "R6 wrap after R8");
    step(0, 0, 0, 0, "R5 hold");
    step(0, 0, 0, 0, "R5 hold again");
    step(1, 508, 3, 0, "R7 set last below base");
    for (int i = 0; i < 10; i++) step(0, 0, 0, 1, "R7 wrap at top");
    step(1, 77, 77, 0, "R6 single entry");
    for (int i = 0; i < 3; i++) step(0, 0, 0, 1, "R6 single entry stays");
    step(1, 100, 355, 0, "R9 set 256 window");
    for (int i = 0; i < 256; i++) step(0, 0, 0, 1, "R9 fill");
    step(0, 0, 0, 0, "R9 back at base");
    chk("R9 explicit base", int'(addr_o), 100);
    lfsr = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[3:0] == 0, int'(lfsr[12:4]), int'({lfsr[6:0], lfsr[15:14]}),
           lfsr[7] | lfsr[5], "R4 R5 R6 R7 R8 mixed");
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule